// File: doc/BRIEF.md
# DMA Minor/Major Loop Sequencer

This block is the control core of one DMA channel. It runs a transfer in two nested loops. The inner loop, called the minor loop, moves a programmed number of bytes as a series of bus beats. The outer loop, called the major loop, repeats the minor loop a programmed number of times. The address and data path sits outside the block. The block asks for beats, counts the bytes those beats complete, and inserts idle stall cycles after each beat when the bandwidth setting calls for them. At the end of each minor loop it updates the iteration counter. From that update it raises interrupts, a request to a linked channel, and the completion flag.

A minor loop is started in one of two ways: a software strobe, or a hardware request while the request enable is set. A debug hold input keeps new minor loops from starting, but a loop that is already running always finishes. While a loop runs, the byte count output shows the bytes still to move in that loop. When the channel is idle, the same output shows the programmed value. The bytes left in the whole transfer are the iteration count times the programmed byte count.

Top module: `xfer_loop_seq`

## Requirements
- R1: One pulse on `swStart` runs exactly one minor loop. That loop issues ceil(cfgNbytes/4) beats (4 bytes per beat) and lowers `citer` by one. A value of 0 in `cfgNbytes` gives a loop with no beats.
- R2: While `active` is high, `nbytesLive` is the live remaining byte count of the current minor loop, and it drops by 4 on each completed beat. While the channel is idle, `nbytesLive` equals `cfgNbytes`.
- R3: When a minor loop ends with `citer` above 1, `citer` drops by one. When it ends with `citer` at 1 or 0, the major loop is complete: `done` is set and `citer` reloads from `cfgBiter`.
- R4: Link mode 1 (minor) pulses `linkReq` at the end of every minor loop. Link mode 2 (major) pulses it only when the major loop completes. Modes 0 and 3 never pulse it. Each pulse lasts one cycle, and `linkCh` carries `cfgLinkCh`.
- R5: Bandwidth codes 0 and 1 insert no stall. Code 2 holds `beatReq` low for 4 cycles after each beat, and code 3 holds it low for 8 cycles.
- R6: When `cfgAutoStop` is 1, the major loop completion clears `reqEn`. When it is 0, `reqEn` keeps its value. `reqEnSet` sets `reqEn` and `reqEnClr` clears it.
- R7: `intMajor` pulses for one cycle on major loop completion when `cfgIntMajorEn` is set. `intHalf` pulses for one cycle when `citer` drops to `cfgBiter/2` (a nonzero value) and `cfgIntHalfEn` is set.
- R8: While `debugHold` is high, no minor loop starts, and a software start received in that time stays pending. A minor loop already running completes normally.
- R9: A pulse on `hwReq` starts a minor loop only while `reqEn` is 1. Otherwise it has no effect.
- R10: Starting a minor loop clears `done`. A `cfgLoad` pulse loads `citer` from `cfgBiter` and clears `done`.
- R11: After each minor loop, the bytes left in the transfer equal `citer` times `cfgNbytes`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| swStart | input | 1 | Software start strobe for one minor loop |
| hwReq | input | 1 | Hardware service request |
| reqEnSet | input | 1 | Sets the hardware request enable |
| reqEnClr | input | 1 | Clears the hardware request enable |
| debugHold | input | 1 | Holds off the start of new minor loops |
| beatDone | input | 1 | Bus reports the requested beat complete |
| cfgLoad | input | 1 | Loads citer from cfgBiter and clears done |
| cfgNbytes | input | NB_W | Bytes per minor loop |
| cfgBiter | input | IT_W | Starting iteration count |
| cfgLinkMode | input | 2 | 0/3 none, 1 minor link, 2 major link |
| cfgLinkCh | input | CH_W | Channel number to link to |
| cfgBw | input | 2 | Bandwidth stall code |
| cfgAutoStop | input | 1 | Clear request enable at major completion |
| cfgIntHalfEn | input | 1 | Enable half-way interrupt |
| cfgIntMajorEn | input | 1 | Enable major completion interrupt |
| beatReq | output | 1 | Request for a bus beat |
| active | output | 1 | A minor loop is running |
| nbytesLive | output | NB_W | Live minor loop byte count, or programmed value when idle |
| citer | output | IT_W | Current iteration count |
| done | output | 1 | Major loop complete flag |
| intHalf | output | 1 | Half-way interrupt pulse |
| intMajor | output | 1 | Major completion interrupt pulse |
| linkReq | output | 1 | One-cycle request to the linked channel |
| linkCh | output | CH_W | Linked channel number |
| reqEn | output | 1 | Hardware request enable |

## Verification
The loop is driven by the software strobe, by hardware requests with the enable set, and by hardware requests with the enable cleared. Comparing these shows whether the request gating is right. Byte counts that are not multiples of the beat size and a zero byte count check the beat count. Iteration counts of 1, 2, 3 and 4 separate a plain decrement from completion, reload and the half-way point. A bus that holds back its acknowledge shows the live count between beats, and it shows that a debug hold raised mid-loop does not cut the running loop short. The stall codes are measured as the gap between beats, so each of the stall lengths is checked separately.

// File: rtl/xls_pkg.sv
package xls_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BEAT   = 2'd1,
    ST_STALL  = 2'd2,
    ST_FINISH = 2'd3
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCnt;   // minor loop begins: load byte counter
    logic beatDec;   // one beat completed
    logic minorEnd;  // minor loop finished: iteration bookkeeping
  } seqStrobe_t;

  localparam logic [1:0] LINK_MINOR = 2'd1;
  localparam logic [1:0] LINK_MAJOR = 2'd2;
  localparam int         STALL_W    = 4;

  function automatic logic [STALL_W-1:0] stallLen(input logic [1:0] code);
    case (code)
      2'd2:    stallLen = STALL_W'(4);
      2'd3:    stallLen = STALL_W'(8);
      default: stallLen = '0;
    endcase
  endfunction

endpackage

// File: rtl/xls_ctrl.sv
module xls_ctrl
  import xls_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       swStart,
  input  logic       hwReq,
  input  logic       reqEn,
  input  logic       debugHold,
  input  logic       beatDone,
  input  logic [1:0] cfgBw,
  input  logic       nbZero,
  input  logic       cntLastBeat,
  output seqStrobe_t stb,
  output logic       beatReq,
  output logic       active
);

  seqState_t          state, stateNext;
  logic [STALL_W-1:0] stallCnt, stallCntNext;
  logic [STALL_W-1:0] stallN;
  logic               lastBeat, lastBeatNext;
  logic               swPend;
  logic               go;

  assign stallN = stallLen(cfgBw);
  assign go     = (swPend | swStart | (hwReq & reqEn)) & ~debugHold;

  always_comb begin
    stateNext    = state;
    stallCntNext = stallCnt;
    lastBeatNext = lastBeat;
    stb          = '0;
    beatReq      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (go) begin
          stb.loadCnt = 1'b1;
          stateNext   = nbZero ? ST_FINISH : ST_BEAT;
        end
      end
      ST_BEAT: begin
        beatReq = 1'b1;
        if (beatDone) begin
          stb.beatDec  = 1'b1;
          lastBeatNext = cntLastBeat;
          if (stallN != '0) begin
            stateNext    = ST_STALL;
            stallCntNext = stallN - STALL_W'(1);
          end else begin
            stateNext = cntLastBeat ? ST_FINISH : ST_BEAT;
          end
        end
      end
      ST_STALL: begin
        if (stallCnt == '0) stateNext = lastBeat ? ST_FINISH : ST_BEAT;
        else                stallCntNext = stallCnt - STALL_W'(1);
      end
      ST_FINISH: begin
        stb.minorEnd = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stallCnt <= '0;
      lastBeat <= 1'b0;
      swPend   <= 1'b0;
    end else begin
      state    <= stateNext;
      stallCnt <= stallCntNext;
      lastBeat <= lastBeatNext;
      swPend   <= (swPend | swStart) & ~stb.loadCnt;
    end
  end

  assign active = (state != ST_IDLE);

  // R8: debug hold keeps an idle channel idle
  p_debug_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && debugHold) |=> (state == ST_IDLE));

  // R5: with a stall code a beat is never followed directly by another request
  p_stall_gap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (beatReq && beatDone && cfgBw[1]) |=> !beatReq);

  // R1: a beat is only requested while a loop is running
  p_beat_in_loop_r1: assert property (@(posedge clk) disable iff (!rstN)
    beatReq |-> active);

endmodule

// File: rtl/xls_dp.sv
module xls_dp
  import xls_pkg::*;
#(
  parameter int NB_W       = 16,
  parameter int IT_W       = 15,
  parameter int CH_W       = 5,
  parameter int BEAT_BYTES = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobe_t      stb,
  input  logic            active,
  input  logic            cfgLoad,
  input  logic            reqEnSet,
  input  logic            reqEnClr,
  input  logic [NB_W-1:0] cfgNbytes,
  input  logic [IT_W-1:0] cfgBiter,
  input  logic [1:0]      cfgLinkMode,
  input  logic [CH_W-1:0] cfgLinkCh,
  input  logic            cfgAutoStop,
  input  logic            cfgIntHalfEn,
  input  logic            cfgIntMajorEn,
  output logic            nbZero,
  output logic            cntLastBeat,
  output logic [NB_W-1:0] nbytesLive,
  output logic [IT_W-1:0] citer,
  output logic            done,
  output logic            intHalf,
  output logic            intMajor,
  output logic            linkReq,
  output logic [CH_W-1:0] linkCh,
  output logic            reqEn
);

  localparam logic [NB_W-1:0] BEAT_N = NB_W'(BEAT_BYTES);

  logic [NB_W-1:0] cnt;
  logic            lastIter;
  logic [IT_W-1:0] citerDec;
  logic            halfHit;
  logic            linkFire;

  assign nbZero      = (cfgNbytes == '0);
  assign cntLastBeat = (cnt <= BEAT_N);
  assign lastIter    = (citer <= IT_W'(1));
  assign citerDec    = citer - IT_W'(1);
  assign halfHit     = !lastIter && (citerDec == (cfgBiter >> 1));
  assign linkFire    = (cfgLinkMode == LINK_MINOR) ||
                       ((cfgLinkMode == LINK_MAJOR) && lastIter);
  assign nbytesLive  = active ? cnt : cfgNbytes;

  // Live minor loop byte counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (stb.loadCnt) cnt <= cfgNbytes;
    else if (stb.beatDec) cnt <= cntLastBeat ? '0 : cnt - BEAT_N;
  end

  // Iteration counter and completion flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      citer <= '0;
      done  <= 1'b0;
    end else if (stb.minorEnd) begin
      if (lastIter) begin
        citer <= cfgBiter;
        done  <= 1'b1;
      end else begin
        citer <= citerDec;
      end
    end else if (cfgLoad) begin
      citer <= cfgBiter;
      done  <= 1'b0;
    end else if (stb.loadCnt) begin
      done <= 1'b0;
    end
  end

  // Event pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intHalf  <= 1'b0;
      intMajor <= 1'b0;
      linkReq  <= 1'b0;
      linkCh   <= '0;
    end else begin
      intHalf  <= stb.minorEnd && cfgIntHalfEn && halfHit;
      intMajor <= stb.minorEnd && cfgIntMajorEn && lastIter;
      linkReq  <= stb.minorEnd && linkFire;
      if (stb.minorEnd && linkFire) linkCh <= cfgLinkCh;
    end
  end

  // Hardware request enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        reqEn <= 1'b0;
    else if (stb.minorEnd && lastIter && cfgAutoStop) reqEn <= 1'b0;
    else if (reqEnClr)                                reqEn <= 1'b0;
    else if (reqEnSet)                                reqEn <= 1'b1;
  end

  // R2: the counter drops by one beat of bytes per completed beat
  p_live_count_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.beatDec && cnt > BEAT_N) |=> (cnt == $past(cnt) - BEAT_N));

  // R3: plain decrement before exhaustion
  p_citer_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.minorEnd && citer > IT_W'(1)) |=> (citer == $past(citer) - IT_W'(1)));

  // R3: exhaustion sets done and reloads
  p_exhaust_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.minorEnd && citer <= IT_W'(1)) |=> (done && citer == $past(cfgBiter)));

  // R4: link request lasts exactly one cycle
  p_link_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    linkReq |=> !linkReq);

  // R6: auto-stop clears the enable at completion
  p_autostop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.minorEnd && citer <= IT_W'(1) && cfgAutoStop) |=> !reqEn);

  // R7: half and major interrupts never coincide
  p_irq_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(intHalf && intMajor));

endmodule

// File: rtl/xfer_loop_seq.sv
module xfer_loop_seq
  import xls_pkg::*;
#(
  parameter int NB_W       = 16,
  parameter int IT_W       = 15,
  parameter int CH_W       = 5,
  parameter int BEAT_BYTES = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            swStart,
  input  logic            hwReq,
  input  logic            reqEnSet,
  input  logic            reqEnClr,
  input  logic            debugHold,
  input  logic            beatDone,
  input  logic            cfgLoad,
  input  logic [NB_W-1:0] cfgNbytes,
  input  logic [IT_W-1:0] cfgBiter,
  input  logic [1:0]      cfgLinkMode,
  input  logic [CH_W-1:0] cfgLinkCh,
  input  logic [1:0]      cfgBw,
  input  logic            cfgAutoStop,
  input  logic            cfgIntHalfEn,
  input  logic            cfgIntMajorEn,
  output logic            beatReq,
  output logic            active,
  output logic [NB_W-1:0] nbytesLive,
  output logic [IT_W-1:0] citer,
  output logic            done,
  output logic            intHalf,
  output logic            intMajor,
  output logic            linkReq,
  output logic [CH_W-1:0] linkCh,
  output logic            reqEn
);

  seqStrobe_t stb;
  logic       nbZero;
  logic       cntLastBeat;

  xls_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .swStart     (swStart),
    .hwReq       (hwReq),
    .reqEn       (reqEn),
    .debugHold   (debugHold),
    .beatDone    (beatDone),
    .cfgBw       (cfgBw),
    .nbZero      (nbZero),
    .cntLastBeat (cntLastBeat),
    .stb         (stb),
    .beatReq     (beatReq),
    .active      (active)
  );

  xls_dp #(
    .NB_W       (NB_W),
    .IT_W       (IT_W),
    .CH_W       (CH_W),
    .BEAT_BYTES (BEAT_BYTES)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .active        (active),
    .cfgLoad       (cfgLoad),
    .reqEnSet      (reqEnSet),
    .reqEnClr      (reqEnClr),
    .cfgNbytes     (cfgNbytes),
    .cfgBiter      (cfgBiter),
    .cfgLinkMode   (cfgLinkMode),
    .cfgLinkCh     (cfgLinkCh),
    .cfgAutoStop   (cfgAutoStop),
    .cfgIntHalfEn  (cfgIntHalfEn),
    .cfgIntMajorEn (cfgIntMajorEn),
    .nbZero        (nbZero),
    .cntLastBeat   (cntLastBeat),
    .nbytesLive    (nbytesLive),
    .citer         (citer),
    .done          (done),
    .intHalf       (intHalf),
    .intMajor      (intMajor),
    .linkReq       (linkReq),
    .linkCh        (linkCh),
    .reqEn         (reqEn)
  );

endmodule

// File: tb/sim_xfer_loop_seq.sv
`timescale 1ns/100ps
module sim_xfer_loop_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swStart = 0, hwReq = 0, reqEnSet = 0, reqEnClr = 0, debugHold = 0;
  logic        cfgLoad = 0, ackEn = 1;
  logic [15:0] cfgNbytes = 0;
  logic [14:0] cfgBiter = 0;
  logic [1:0]  cfgLinkMode = 0, cfgBw = 0;
  logic [4:0]  cfgLinkCh = 0;
  logic        cfgAutoStop = 0, cfgIntHalfEn = 0, cfgIntMajorEn = 0;
  logic        beatReq, beatDone, active, done, intHalf, intMajor, linkReq, reqEn;
  logic [15:0] nbytesLive;
  logic [14:0] citer;
  logic [4:0]  linkCh;

  int checks = 0, errors = 0;
  int beatCnt = 0, halfCnt = 0, majCnt = 0, linkCnt = 0, lastLinkCh = 0;
  int gapRun = 0, lastGap = 0;
  int expCiter = 0;

  always #2 clk = ~clk;  // 250 MHz

  assign beatDone = beatReq & ackEn;

  xfer_loop_seq u0 (
    .clk(clk), .rstN(rstN), .swStart(swStart), .hwReq(hwReq),
    .reqEnSet(reqEnSet), .reqEnClr(reqEnClr), .debugHold(debugHold),
    .beatDone(beatDone), .cfgLoad(cfgLoad), .cfgNbytes(cfgNbytes),
    .cfgBiter(cfgBiter), .cfgLinkMode(cfgLinkMode), .cfgLinkCh(cfgLinkCh),
    .cfgBw(cfgBw), .cfgAutoStop(cfgAutoStop), .cfgIntHalfEn(cfgIntHalfEn),
    .cfgIntMajorEn(cfgIntMajorEn), .beatReq(beatReq), .active(active),
    .nbytesLive(nbytesLive), .citer(citer), .done(done), .intHalf(intHalf),
    .intMajor(intMajor), .linkReq(linkReq), .linkCh(linkCh), .reqEn(reqEn)
  );

  // Monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (beatReq && ackEn) beatCnt++;
    if (intHalf)  halfCnt++;
    if (intMajor) majCnt++;
    if (linkReq) begin linkCnt++; lastLinkCh = int'(linkCh); end
    if (!active) gapRun = 0;
    else if (!beatReq) gapRun++;
    else begin
      if (gapRun > 0) lastGap = gapRun;
      gapRun = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Inputs change 1 ns after the rising edge
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic waitIdle();
    while (active) step();
    settle();
  endtask

  task automatic configure(input int nb, input int bi, input int lm, input int ch,
                           input int bw, input bit as, input bit ih, input bit im);
    step();
    cfgNbytes = 16'(nb); cfgBiter = 15'(bi); cfgLinkMode = 2'(lm);
    cfgLinkCh = 5'(ch); cfgBw = 2'(bw); cfgAutoStop = as;
    cfgIntHalfEn = ih; cfgIntMajorEn = im; cfgLoad = 1;
    step();
    cfgLoad = 0;
    expCiter = bi;
  endtask

  function automatic void advance();
    if (expCiter <= 1) expCiter = int'(cfgBiter);
    else expCiter--;
  endfunction

  task automatic runSw();
    step(); swStart = 1;
    step(); swStart = 0;
    waitIdle();
    advance();
  endtask

  task automatic runHw();
    step(); hwReq = 1;
    step(); hwReq = 0;
    waitIdle();
    advance();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R3 reset citer", citer, 0);
    chk("R3 reset done", done, 0);
    chk("R1 reset beatReq", beatReq, 0);
    chk("R6 reset reqEn", reqEn, 0);
    chk("R4 reset linkReq", linkReq, 0);
  endtask

  task automatic t_basic();
    int b0;
    configure(12, 3, 0, 0, 0, 0, 0, 1);
    chk("R10 load citer", citer, 3);
    b0 = beatCnt; runSw();
    chk("R1 beats per loop", beatCnt - b0, 3);
    chk("R3 citer step", citer, 2);
    chk("R11 remaining bytes", citer * cfgNbytes, 24);
    runSw();
    chk("R3 citer step 2", citer, expCiter);
    chk("R3 done still low", done, 0);
    b0 = majCnt; runSw();
    chk("R3 done at exhaustion", done, 1);
    chk("R3 reload from biter", citer, 3);
    chk("R7 major irq", majCnt - b0, 1);
    chk("R11 remaining after reload", citer * cfgNbytes, expCiter * 12);
    // odd byte count: 10 bytes -> 3 beats
    configure(10, 2, 0, 0, 0, 0, 0, 0);
    b0 = beatCnt; runSw();
    chk("R1 partial beat count", beatCnt - b0, 3);
    // zero bytes -> no beats, still an iteration
    configure(0, 2, 0, 0, 0, 0, 0, 0);
    b0 = beatCnt; runSw();
    chk("R1 zero-byte beats", beatCnt - b0, 0);
    chk("R1 zero-byte citer", citer, 1);
  endtask

  task automatic t_live();
    configure(12, 4, 0, 0, 0, 0, 0, 0);
    chk("R2 idle shows programmed", nbytesLive, 12);
    ackEn = 0;
    step(); swStart = 1;
    step(); swStart = 0;
    @(negedge clk);
    chk("R2 live at start", nbytesLive, 12);
    step(); ackEn = 1;
    step(); ackEn = 0;
    @(negedge clk);
    chk("R2 live after one beat", nbytesLive, 8);
    step(); ackEn = 1;
    waitIdle(); advance();
    chk("R2 idle after loop", nbytesLive, 12);
  endtask

  task automatic t_bw();
    int codes[4] = '{0, 1, 2, 3};
    int gaps[4]  = '{0, 0, 4, 8};
    foreach (codes[i]) begin
      configure(8, 4, 0, 0, codes[i], 0, 0, 0);
      lastGap = 0;
      runSw();
      chk($sformatf("R5 stall gap code %0d", codes[i]), lastGap, gaps[i]);
    end
  endtask

  task automatic t_link();
    int l0;
    configure(4, 2, 1, 7, 0, 0, 0, 0);
    l0 = linkCnt; runSw();
    chk("R4 minor link first", linkCnt - l0, 1);
    chk("R4 minor link channel", lastLinkCh, 7);
    runSw();
    chk("R4 minor link second", linkCnt - l0, 2);
    configure(4, 2, 2, 9, 0, 0, 0, 0);
    l0 = linkCnt; runSw();
    chk("R4 major link not yet", linkCnt - l0, 0);
    runSw();
    chk("R4 major link at end", linkCnt - l0, 1);
    chk("R4 major link channel", lastLinkCh, 9);
    configure(4, 1, 3, 3, 0, 0, 0, 0);
    l0 = linkCnt; runSw();
    chk("R4 mode 3 no link", linkCnt - l0, 0);
  endtask

  task automatic t_irq();
    int h0, m0;
    configure(4, 4, 0, 0, 0, 0, 1, 1);
    h0 = halfCnt; m0 = majCnt;
    runSw();
    chk("R7 no half at 3", halfCnt - h0, 0);
    runSw();
    chk("R7 half at 2", halfCnt - h0, 1);
    runSw(); runSw();
    chk("R7 major once", majCnt - m0, 1);
    chk("R7 half once", halfCnt - h0, 1);
    configure(4, 2, 0, 0, 0, 0, 0, 0);
    h0 = halfCnt; m0 = majCnt;
    runSw(); runSw();
    chk("R7 disabled half", halfCnt - h0, 0);
    chk("R7 disabled major", majCnt - m0, 0);
  endtask

  task automatic t_hw();
    configure(4, 2, 0, 0, 0, 1, 0, 0);
    step(); hwReq = 1;
    step(); hwReq = 0;
    settle();
    chk("R9 hw ignored when disabled", citer, 2);
    chk("R9 no loop when disabled", active, 0);
    step(); reqEnSet = 1;
    step(); reqEnSet = 0;
    @(negedge clk);
    chk("R6 reqEnSet", reqEn, 1);
    runHw();
    chk("R9 hw loop runs", citer, 1);
    chk("R6 enable kept mid-transfer", reqEn, 1);
    runHw();
    chk("R6 auto-stop clears enable", reqEn, 0);
    configure(4, 1, 0, 0, 0, 0, 0, 0);
    step(); reqEnSet = 1;
    step(); reqEnSet = 0;
    runHw();
    chk("R6 no auto-stop keeps enable", reqEn, 1);
    step(); reqEnClr = 1;
    step(); reqEnClr = 0;
    @(negedge clk);
    chk("R6 reqEnClr", reqEn, 0);
  endtask

  task automatic t_debug();
    configure(8, 3, 0, 0, 0, 0, 0, 0);
    step(); debugHold = 1; swStart = 1;
    step(); swStart = 0;
    repeat (10) step();
    @(negedge clk);
    chk("R8 held off active", active, 0);
    chk("R8 held off citer", citer, 3);
    step(); debugHold = 0;
    step();
    waitIdle(); advance();
    chk("R8 pending start runs", citer, 2);
    ackEn = 0;
    step(); swStart = 1;
    step(); swStart = 0; debugHold = 1;
    step(); ackEn = 1;
    waitIdle(); advance();
    chk("R8 running loop completes", citer, 1);
    step(); debugHold = 0;
  endtask

  task automatic t_done_clear();
    configure(4, 1, 0, 0, 0, 0, 0, 0);
    runSw();
    chk("R10 done set", done, 1);
    ackEn = 0;
    step(); swStart = 1;
    step(); swStart = 0;
    @(negedge clk);
    chk("R10 start clears done", done, 0);
    step(); ackEn = 1;
    waitIdle(); advance();
    chk("R10 done again", done, 1);
    configure(4, 5, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R10 load clears done", done, 0);
    chk("R10 load sets citer", citer, 5);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    t_reset();
    t_basic();
    t_live();
    t_bw();
    t_link();
    t_irq();
    t_hw();
    t_debug();
    t_done_clear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule